// File: doc/BRIEF.md
# Light-Load Power-Save Mode Controller

This block sits in the digital control path of a constant on-time buck converter and decides, one switching cycle at a time, whether the converter runs in continuous conduction or in a discontinuous power-save mode. It sees only per-cycle event flags: a strobe at the end of each switching cycle, a pulse when the inductor current crosses zero, a two-bit operating mode taken from the enable input, and a comparator that trips when the output stands well above nominal. The analog sensing behind these flags lies outside the block.

Power-save is entered only after a run of consecutive switching cycles in which the inductor current reached zero. A single cycle without a crossing drops the mode at once. While in power-save, the block asks the low-side driver to turn off at the zero crossing and asks the on-time one-shot for a longer pulse. Apart from this, a soft over-voltage assist holds the low-side switch on to pull the output down until feedback falls back to the trip point. It then signals that a normal on cycle may start, so the converter does not have to shut down hard.

Top module: `lightload_psave_ctrl`

## Requirements
- R1: Power-save requires a run of consecutive crossing cycles. `ps_state` rises at the end strobe of the eighth such cycle (parameter `ENTRY_CYCLES`, default 8), and not at any earlier strobe.
- R2: At the end strobe of a cycle in which no crossing occurred, `ps_state` goes to 0 and the run count is cleared. Seven further crossing cycles therefore do not re-enter power-save.
- R3: A crossing counts for its cycle whether `zc_now` pulses before the end strobe or in the same clock as `cyc_end`.
- R4: `lsoff_req` is high exactly when `ps_state` and `zc_now` are both high.
- R5: `ton_ext` equals `ps_state`.
- R6: `mode_sel` encodes 2'b00 off, 2'b01 enabled in continuous conduction, 2'b10 enabled with power-save, and 2'b11 off. In any mode other than 2'b10, `ps_state` is 0 from the next clock and the run count is held at 0.
- R7: The run count saturates at the entry value. Once in power-save, any number of consecutive crossing cycles keeps `ps_state` at 1.
- R8: In modes 2'b01 and 2'b10, `ov_soft` high sets `force_ls` from the next clock. `force_ls` then stays high until `fb_trip` is high while `ov_soft` is low. `ov_soft` takes precedence over `fb_trip`.
- R9: When `force_ls` is released by `fb_trip`, `resume_on` is high for exactly one clock, in the same clock in which `force_ls` falls.
- R10: In modes 2'b00 and 2'b11, `force_ls` and `resume_on` are 0 from the next clock and `ov_soft` is ignored.
- R11: While reset is held, and after it is released, `ps_state`, `force_ls`, `resume_on`, `lsoff_req` and `ton_ext` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 2 | Operating mode from the enable input (see R6) |
| cyc_end | input | 1 | One-clock strobe at the end of each switching cycle |
| zc_now | input | 1 | Pulse when the inductor current crosses zero |
| ov_soft | input | 1 | Output above the soft over-voltage level |
| fb_trip | input | 1 | Feedback at or below the normal trip point |
| ps_state | output | 1 | Power-save mode active |
| lsoff_req | output | 1 | Turn the low-side switch off now |
| ton_ext | output | 1 | Request a lengthened on-time |
| force_ls | output | 1 | Hold the low-side switch on |
| resume_on | output | 1 | One-clock permission to start a normal on cycle |

## Verification
The assertions assume that `cyc_end` is a single-clock strobe and that a crossing belongs to the cycle whose strobe follows it. They also assume that `mode_sel` changes on clock boundaries, so the crossing history the checker keeps per cycle matches what the block sees. The stimulus generates whole switching cycles of four clocks. Each cycle has at most one crossing pulse, placed either before the strobe or on it, and every input changes on the falling edge. The over-voltage tests raise `ov_soft` and `fb_trip` as held levels, including one clock where both are high, to exercise the precedence rule.

// File: rtl/lm_pkg.sv
package lm_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_CCM = 2'b01,
    MODE_PSV = 2'b10,
    MODE_RSV = 2'b11
  } lm_mode_e;

  localparam int unsigned LM_ENTRY_DEFAULT = 8;
  localparam int unsigned LM_SYNC_DEFAULT  = 2;
endpackage

// File: rtl/lm_rst_sync.sv
module lm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n_in) begin
        if (!rst_n_in) sync_q <= '0;
        else           sync_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n_in) begin
        if (!rst_n_in) sync_q <= '0;
        else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/lm_zc_tracker.sv
module lm_zc_tracker #(
  parameter int unsigned ENTRY_CYCLES = 8,
  parameter int unsigned CNT_W        = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  input  logic cyc_end,
  input  logic zc_now,
  output logic cyc_zc,
  output logic run_full
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ENTRY_CYCLES);

  logic             hit_q, hit_d, hit_en;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // crossing seen anywhere in the current cycle, including the strobe clock
  assign cyc_zc = hit_q | zc_now;

  always_comb begin
    hit_en = cyc_end | zc_now | ~allow;
    if (!allow || cyc_end) hit_d = 1'b0;
    else                   hit_d = 1'b1;
  end

  always_comb begin
    cnt_en = cyc_end | ~allow;
    cnt_d  = cnt_q;
    if (!allow) begin
      cnt_d = '0;
    end else if (cyc_end) begin
      if (!cyc_zc)              cnt_d = '0;
      else if (cnt_q < CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
      else                      cnt_d = CNT_MAX;
    end
  end

  assign run_full = (cnt_d == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hit_q <= 1'b0;
    else if (hit_en) hit_q <= hit_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lm_ps_state.sv
module lm_ps_state (
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  input  logic cyc_end,
  input  logic cyc_zc,
  input  logic run_full,
  output logic ps_q
);
  logic ps_d, ps_en;

  always_comb begin
    ps_en = cyc_end | ~allow;
    if (!allow)       ps_d = 1'b0;
    else if (!cyc_zc) ps_d = 1'b0;
    else              ps_d = run_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ps_q <= 1'b0;
    else if (ps_en) ps_q <= ps_d;
  end
endmodule

// File: rtl/lm_ov_assist.sv
module lm_ov_assist (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ov_soft,
  input  logic fb_trip,
  output logic force_q,
  output logic resume_q
);
  logic force_d, resume_d;

  always_comb begin
    force_d  = force_q;
    resume_d = 1'b0;
    if (!active) begin
      force_d = 1'b0;
    end else if (ov_soft) begin
      force_d = 1'b1;
    end else if (force_q && fb_trip) begin
      force_d  = 1'b0;
      resume_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_q  <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      force_q  <= force_d;
      resume_q <= resume_d;
    end
  end
endmodule

// File: rtl/lightload_psave_ctrl.sv
module lightload_psave_ctrl #(
  parameter int unsigned ENTRY_CYCLES = lm_pkg::LM_ENTRY_DEFAULT,
  parameter int unsigned SYNC_STAGES  = lm_pkg::LM_SYNC_DEFAULT
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       cyc_end,
  input  logic       zc_now,
  input  logic       ov_soft,
  input  logic       fb_trip,
  output logic       ps_state,
  output logic       lsoff_req,
  output logic       ton_ext,
  output logic       force_ls,
  output logic       resume_on
);
  import lm_pkg::*;

  localparam int unsigned CNT_W = $clog2(ENTRY_CYCLES + 1);

  logic rst_sync_n;
  logic allow, active;
  logic cyc_zc, run_full;

  assign allow  = (mode_sel == MODE_PSV);
  assign active = (mode_sel == MODE_PSV) || (mode_sel == MODE_CCM);

  lm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  lm_zc_tracker #(.ENTRY_CYCLES(ENTRY_CYCLES), .CNT_W(CNT_W)) u_trk (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .allow    (allow),
    .cyc_end  (cyc_end),
    .zc_now   (zc_now),
    .cyc_zc   (cyc_zc),
    .run_full (run_full)
  );

  lm_ps_state u_ps (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .allow    (allow),
    .cyc_end  (cyc_end),
    .cyc_zc   (cyc_zc),
    .run_full (run_full),
    .ps_q     (ps_state)
  );

  lm_ov_assist u_ov (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .active   (active),
    .ov_soft  (ov_soft),
    .fb_trip  (fb_trip),
    .force_q  (force_ls),
    .resume_q (resume_on)
  );

  assign lsoff_req = ps_state & zc_now;
  assign ton_ext   = ps_state;
endmodule

// File: rtl/lm_psave_chk.sv
module lm_psave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       cyc_end,
  input logic       zc_now,
  input logic       ov_soft,
  input logic       fb_trip,
  input logic       ps_state,
  input logic       lsoff_req,
  input logic       force_ls,
  input logic       resume_on
);
  logic zc_in_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       zc_in_cyc <= 1'b0;
    else if (cyc_end) zc_in_cyc <= 1'b0;
    else if (zc_now)  zc_in_cyc <= 1'b1;
  end

  // R1
  entry_at_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps_state) |-> ($past(cyc_end) && $past(mode_sel) == 2'b10));

  // R2
  exit_no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !zc_now && !zc_in_cyc) |=> !ps_state);

  // R7
  stay_in_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_state && cyc_end && (zc_now || zc_in_cyc) && mode_sel == 2'b10) |=> ps_state);

  // R4
  lsoff_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsoff_req |-> (ps_state && zc_now));

  // R6
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b10) |=> !ps_state);

  // R8
  force_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_soft && (mode_sel == 2'b01 || mode_sel == 2'b10)) |=> force_ls);

  // R8
  force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ls && !fb_trip && (mode_sel == 2'b01 || mode_sel == 2'b10)) |=> force_ls);

  // R9
  resume_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_on |-> $fell(force_ls));

  // R9
  resume_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_on |=> !resume_on);

  // R10
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 || mode_sel == 2'b11) |=> (!force_ls && !resume_on));
endmodule

bind lightload_psave_ctrl lm_psave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .mode_sel  (mode_sel),
  .cyc_end   (cyc_end),
  .zc_now    (zc_now),
  .ov_soft   (ov_soft),
  .fb_trip   (fb_trip),
  .ps_state  (ps_state),
  .lsoff_req (lsoff_req),
  .force_ls  (force_ls),
  .resume_on (resume_on)
);

// File: tb/lightload_psave_ctrl_test.sv
module lightload_psave_ctrl_test;
  logic       clk;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic       cyc_end, zc_now, ov_soft, fb_trip;
  logic       ps_state, lsoff_req, ton_ext, force_ls, resume_on;

  int checks;
  int errors;
  bit done;

  int ref_cnt;
  bit ref_ps;

  localparam logic [1:0] M_OFF = 2'b00;
  localparam logic [1:0] M_CCM = 2'b01;
  localparam logic [1:0] M_PSV = 2'b10;
  localparam logic [1:0] M_RSV = 2'b11;
  localparam int ENTRY = 8;

  // each entry: {mode[1:0], crossing position[1:0]}; 0 none, 1 early, 2 on the strobe
  localparam int NVEC = 34;
  localparam logic [3:0] VEC [0:NVEC-1] = '{
    4'b1001, 4'b1001, 4'b1001, 4'b1001, 4'b1001, 4'b1001, 4'b1001, 4'b1001,
    4'b1010, 4'b1010, 4'b1001,
    4'b1000,
    4'b1001, 4'b1010, 4'b1001, 4'b1010, 4'b1001, 4'b1010, 4'b1001,
    4'b1010,
    4'b0101,
    4'b1001, 4'b1001, 4'b1001, 4'b1001,
    4'b0001,
    4'b1010, 4'b1010, 4'b1010, 4'b1010, 4'b1010, 4'b1010, 4'b1010, 4'b1010
  };

  lightload_psave_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .cyc_end   (cyc_end),
    .zc_now    (zc_now),
    .ov_soft   (ov_soft),
    .fb_trip   (fb_trip),
    .ps_state  (ps_state),
    .lsoff_req (lsoff_req),
    .ton_ext   (ton_ext),
    .force_ls  (force_ls),
    .resume_on (resume_on)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step_negedge();
    @(negedge clk);
  endtask

  // reference model of the requirements, one cycle at a time
  task automatic model_cycle(input logic [1:0] m, input bit crossed);
    if (m != M_PSV) begin
      ref_cnt = 0; ref_ps = 0;
    end else if (crossed) begin
      if (ref_cnt < ENTRY) ref_cnt++;
      ref_ps = (ref_cnt == ENTRY);
    end else begin
      ref_cnt = 0; ref_ps = 0;
    end
  endtask

  // one switching cycle of four clocks
  task automatic run_cycle(input logic [1:0] m, input logic [1:0] zpos);
    bit prev_ps;
    prev_ps = ref_ps;
    step_negedge();
    mode_sel = m; zc_now = 1'b0; cyc_end = 1'b0;
    step_negedge();
    zc_now = (zpos == 2'd1);
    #1;
    if (zpos == 2'd1) check("R4 lsoff_req on early crossing", lsoff_req, prev_ps && (m == M_PSV));
    else              check("R4 lsoff_req idle", lsoff_req, 1'b0);
    check("R5 ton_ext", ton_ext, prev_ps && (m == M_PSV));
    step_negedge();
    zc_now = (zpos == 2'd2); cyc_end = 1'b1;
    step_negedge();
    zc_now = 1'b0; cyc_end = 1'b0;
    model_cycle(m, zpos != 2'd0);
    #1;
    check("R1 R2 R3 R6 ps_state after strobe", ps_state, ref_ps);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    ref_cnt = 0; ref_ps = 0;
    rst_n = 1'b0; mode_sel = M_PSV; cyc_end = 1'b0; zc_now = 1'b0;
    ov_soft = 1'b0; fb_trip = 1'b0;
    repeat (3) step_negedge();
    #1;
    // R11 reset state
    check("R11 ps_state in reset", ps_state, 1'b0);
    check("R11 force_ls in reset", force_ls, 1'b0);
    check("R11 resume_on in reset", resume_on, 1'b0);
    check("R11 ton_ext in reset", ton_ext, 1'b0);
    rst_n = 1'b1;
    repeat (4) step_negedge();
    #1;
    check("R11 ps_state after release", ps_state, 1'b0);
    check("R11 lsoff_req after release", lsoff_req, 1'b0);

    // table of whole switching cycles
    for (int i = 0; i < NVEC; i++) begin
      run_cycle(VEC[i][3:2], VEC[i][1:0]);
    end

    // R7 saturation: twenty more crossing cycles stay in power-save
    for (int i = 0; i < 20; i++) begin
      run_cycle(M_PSV, 2'd2);
    end
    check("R7 still in power-save after long run", ps_state, 1'b1);

    // R6 mid-cycle mode drop clears at the next clock, without a strobe
    step_negedge();
    mode_sel = M_CCM;
    step_negedge();
    #1;
    check("R6 ccm clears ps_state without strobe", ps_state, 1'b0);
    ref_ps = 0; ref_cnt = 0;
    for (int i = 0; i < ENTRY; i++) run_cycle(M_PSV, 2'd1);
    check("R1 re-entry after mode drop", ps_state, 1'b1);
    step_negedge();
    mode_sel = M_RSV;
    step_negedge();
    #1;
    check("R6 code 11 clears ps_state", ps_state, 1'b0);
    ref_ps = 0; ref_cnt = 0;

    // R8 / R9 soft over-voltage assist in continuous conduction
    step_negedge();
    mode_sel = M_CCM; ov_soft = 1'b1;
    step_negedge();
    ov_soft = 1'b0;
    #1;
    check("R8 force_ls set", force_ls, 1'b1);
    repeat (3) step_negedge();
    #1;
    check("R8 force_ls held", force_ls, 1'b1);
    check("R9 resume_on idle while held", resume_on, 1'b0);
    ov_soft = 1'b1; fb_trip = 1'b1;
    step_negedge();
    ov_soft = 1'b0;
    #1;
    check("R8 ov_soft wins over fb_trip", force_ls, 1'b1);
    check("R9 no resume while ov_soft", resume_on, 1'b0);
    step_negedge();
    fb_trip = 1'b0;
    #1;
    check("R8 release on fb_trip", force_ls, 1'b0);
    check("R9 resume pulse", resume_on, 1'b1);
    step_negedge();
    #1;
    check("R9 resume one clock only", resume_on, 1'b0);

    // R10 off modes clear and ignore the assist
    ov_soft = 1'b1;
    step_negedge();
    #1;
    check("R8 force_ls set again", force_ls, 1'b1);
    ov_soft = 1'b0; mode_sel = M_OFF;
    step_negedge();
    #1;
    check("R10 off clears force_ls", force_ls, 1'b0);
    check("R10 off gives no resume", resume_on, 1'b0);
    ov_soft = 1'b1;
    step_negedge();
    mode_sel = M_RSV;
    step_negedge();
    #1;
    check("R10 ov_soft ignored when off", force_ls, 1'b0);
    ov_soft = 1'b0;

    // R8 assist also works in power-save mode
    mode_sel = M_PSV; ov_soft = 1'b1;
    step_negedge();
    ov_soft = 1'b0;
    #1;
    check("R8 force_ls in power-save mode", force_ls, 1'b1);
    fb_trip = 1'b1;
    step_negedge();
    fb_trip = 1'b0;
    #1;
    check("R9 resume in power-save mode", resume_on, 1'b1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule